// File: doc/BRIEF.md
# Paged I2C EEPROM controller

This block is a two-wire serial slave that fronts a 256-byte, byte-wide storage array split into 16 pages of 16 bytes. A bus master selects it with a 7-bit address whose upper five bits are fixed at `10100` and whose two low bits come from strap pins, so four of these blocks can share one bus. One 8-bit address counter serves every access. Writes load the counter from an address byte and then accept any number of data bytes. Reads start wherever the counter points. A random read is made by writing only the address byte and then issuing a repeated start with the read bit set.

Write data is collected in a one-page staging buffer and goes into the array only when a stop condition closes the transaction. That stop also starts an internal write cycle lasting `WRITE_CYCLES` clocks. During the cycle the block refuses its own address, so a master polls with address probes until it gets an acknowledge. An active-low write-protect input turns every write into a no-op while reads keep working. SCL and SDA are sampled with the system clock, and the block pulls SDA low through an open-drain style output.

Top module: `pagedEepromI2c`

## Requirements
- R1: After reset every array byte reads 0xFF, the address counter is 0 and SDA is released (`sdaPullLow` = 0).
- R2: The block acknowledges an address byte whose upper seven bits are `1010 0`, `devSel[1]`, `devSel[0]` (bit 0 is the read/write flag, 1 = read). It leaves every other address unacknowledged and ignores the rest of that transaction.
- R3: A read returns the byte at the counter and then adds one to the counter, wrapping from 255 to 0. A read may run for any number of bytes; the master acknowledges every byte except the last.
- R4: Each written data byte goes to the counter's position. The counter's low four bits then step up, wrapping from 15 to 0, while its upper four bits (the page) stay unchanged. For example, two bytes written from address 31 land at 31 and 16, and the counter ends at 17.
- R5: When more than 16 data bytes are sent in one write, a later byte that lands on an offset already written replaces the earlier one.
- R6: A stop that closes a write carrying at least one data byte starts an internal cycle of `WRITE_CYCLES` clocks. During that cycle the block does not acknowledge its address and stores nothing. After the cycle it acknowledges again.
- R7: A current read begins at the counter value with no address byte. An address byte written and then followed by a repeated start and a read address makes the read begin at that address.
- R8: While `wpN` is low at the closing stop, the array is left unchanged and no internal write cycle starts. Reads behave normally.
- R9: Buffered write data enters the array only at a stop. If a repeated start follows data bytes, that data is discarded and no write cycle starts.
- R10: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Serial clock as seen on the bus |
| sdaIn | input | 1 | Serial data as seen on the bus |
| sdaPullLow | output | 1 | 1 pulls the SDA line low; 0 releases it |
| devSel | input | 2 | Low two bits of the device address |
| wpN | input | 1 | Active-low write protect |

## Verification
The embedded properties check several rules on every clock:
- the page bits of the counter hold steady across a stored byte, and a read step adds exactly one;
- SDA drive stays steady while SCL is high;
- no byte is stored and no address is acknowledged while a write cycle runs;
- a protected stop never starts a write cycle.

Other behaviours only the bench scenarios can show, by comparing read-back data with a model kept in the bench. These are the page-wrap landing points, overwrite after more than 16 bytes, data discarded by a repeated start, the acknowledge-polling sequence, and a read crossing from address 255 to 0.

// File: rtl/eePkg.sv
package eePkg;
  // Strobes from the bus controller to the storage datapath
  typedef struct packed {
    logic loadPtr;    // latch received byte into the address counter
    logic storeByte;  // put received byte in page buffer, step counter in page
    logic bumpRead;   // step counter after a byte has been sent
    logic commit;     // stop seen: flush buffer into array
    logic dropBuf;    // start seen: discard buffered bytes
  } eeStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WORD,
    ST_WDATA,
    ST_READ
  } eeState_t;
endpackage

// File: rtl/eeDatapath.sv
module eeDatapath
  import eePkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int OFS_W        = 4,
  parameter int DATA_W       = 8,
  parameter int WRITE_CYCLES = 1300000
) (
  input  logic              clk,
  input  logic              rstN,
  input  eeStrobe_t         strb,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              wpN,
  output logic [DATA_W-1:0] rdByte,
  output logic              busy
);
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << OFS_W;
  localparam int CNT_W      = $clog2(WRITE_CYCLES + 1);

  logic [DATA_W-1:0]     memArr  [DEPTH];
  logic [DATA_W-1:0]     pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] bufValid;
  logic [ADDR_W-1:0]     ptr;
  logic [CNT_W-1:0]      busyCnt;
  logic                  doFlush;

  assign busy    = (busyCnt != '0);
  assign rdByte  = memArr[ptr];
  assign doFlush = strb.commit && wpN && (bufValid != '0);

  // Staging buffer contents: validity is tracked separately
  always_ff @(posedge clk) begin
    if (strb.storeByte) pageBuf[ptr[OFS_W-1:0]] <= dataIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) memArr[i] <= '1;
      ptr      <= '0;
      bufValid <= '0;
      busyCnt  <= '0;
    end else begin
      if (busyCnt != '0) busyCnt <= busyCnt - 1'b1;
      if (strb.loadPtr) ptr <= dataIn[ADDR_W-1:0];
      if (strb.storeByte) begin
        bufValid[ptr[OFS_W-1:0]] <= 1'b1;
        ptr <= {ptr[ADDR_W-1:OFS_W], ptr[OFS_W-1:0] + 1'b1};
      end
      if (strb.bumpRead) ptr <= ptr + 1'b1;
      if (strb.dropBuf) bufValid <= '0;
      if (strb.commit) begin
        if (doFlush) begin
          for (int i = 0; i < PAGE_BYTES; i++)
            if (bufValid[i]) memArr[{ptr[ADDR_W-1:OFS_W], OFS_W'(i)}] <= pageBuf[i];
          busyCnt <= CNT_W'(WRITE_CYCLES);
        end
        bufValid <= '0;
      end
    end
  end

  AST_WRITE_STAYS_IN_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    strb.storeByte |=> ptr[ADDR_W-1:OFS_W] == $past(ptr[ADDR_W-1:OFS_W])); // R4
  AST_READ_STEP_WRAPS: assert property (@(posedge clk) disable iff (!rstN)
    strb.bumpRead |=> ptr == ADDR_W'($past(ptr) + 1'b1)); // R3
  AST_NO_STORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strb.storeByte); // R6
  AST_PROTECT_NO_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && strb.commit && !wpN) |=> !busy); // R8
endmodule

// File: rtl/eeCtrl.sv
module eeCtrl
  import eePkg::*;
#(
  parameter int         DATA_W     = 8,
  parameter logic [4:0] DEV_PREFIX = 5'b10100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [1:0]        devSel,
  input  logic              busy,
  input  logic [DATA_W-1:0] rdByte,
  output eeStrobe_t         strb,
  output logic [DATA_W-1:0] rxByte,
  output logic              sdaLow
);
  localparam int BIT_W = $clog2(DATA_W + 1);

  logic [2:0]        sclQ, sdaQ;
  logic              sclRise, sclFall, startDet, stopDet;
  logic              ackStart, ackEnd, devHit;
  eeState_t          state;
  logic [BIT_W-1:0]  bitCnt;
  logic              inAck, masterAck;
  logic [DATA_W-1:0] shiftReg, txShift;

  assign sclRise  = sclQ[1] && !sclQ[2];
  assign sclFall  = !sclQ[1] && sclQ[2];
  assign startDet = sclQ[1] && sclQ[2] && !sdaQ[1] && sdaQ[2];
  assign stopDet  = sclQ[1] && sclQ[2] && sdaQ[1] && !sdaQ[2];
  assign ackStart = (state != ST_IDLE) && sclFall && !inAck && (bitCnt == BIT_W'(DATA_W));
  assign ackEnd   = (state != ST_IDLE) && sclFall && inAck;
  assign devHit   = (shiftReg[DATA_W-1:1] == {DEV_PREFIX, devSel}) && !busy;
  assign rxByte   = shiftReg;

  always_comb begin
    strb           = '0;
    strb.dropBuf   = startDet;
    strb.commit    = stopDet;
    strb.loadPtr   = ackStart && (state == ST_WORD);
    strb.storeByte = ackStart && (state == ST_WDATA);
    strb.bumpRead  = ackStart && (state == ST_READ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclQ      <= '1;
      sdaQ      <= '1;
      state     <= ST_IDLE;
      bitCnt    <= '0;
      inAck     <= 1'b0;
      masterAck <= 1'b0;
      shiftReg  <= '0;
      txShift   <= '0;
      sdaLow    <= 1'b0;
    end else begin
      sclQ <= {sclQ[1:0], sclIn};
      sdaQ <= {sdaQ[1:0], sdaIn};
      if (startDet) begin
        state  <= ST_DEV;
        bitCnt <= '0;
        inAck  <= 1'b0;
        sdaLow <= 1'b0;
      end else if (stopDet) begin
        state  <= ST_IDLE;
        bitCnt <= '0;
        inAck  <= 1'b0;
        sdaLow <= 1'b0;
      end else if (state != ST_IDLE) begin
        if (sclRise) begin
          if (inAck) masterAck <= !sdaQ[1];
          else begin
            bitCnt <= bitCnt + 1'b1;
            if (state != ST_READ) shiftReg <= {shiftReg[DATA_W-2:0], sdaQ[1]};
          end
        end
        if (ackStart) begin
          case (state)
            ST_DEV: begin
              if (devHit) begin
                inAck  <= 1'b1;
                sdaLow <= 1'b1;
              end else begin
                state  <= ST_IDLE;
                sdaLow <= 1'b0;
              end
            end
            ST_WORD, ST_WDATA: begin
              inAck  <= 1'b1;
              sdaLow <= 1'b1;
            end
            default: begin
              inAck  <= 1'b1;
              sdaLow <= 1'b0;
            end
          endcase
        end else if (ackEnd) begin
          inAck  <= 1'b0;
          bitCnt <= '0;
          sdaLow <= 1'b0;
          case (state)
            ST_DEV: begin
              if (shiftReg[0]) begin
                state   <= ST_READ;
                txShift <= rdByte;
                sdaLow  <= !rdByte[DATA_W-1];
              end else state <= ST_WORD;
            end
            ST_WORD: state <= ST_WDATA;
            ST_READ: begin
              if (masterAck) begin
                txShift <= rdByte;
                sdaLow  <= !rdByte[DATA_W-1];
              end else state <= ST_IDLE;
            end
            default: state <= state;
          endcase
        end else if (sclFall && state == ST_READ && !inAck && bitCnt != '0) begin
          txShift <= {txShift[DATA_W-2:0], 1'b0};
          sdaLow  <= !txShift[DATA_W-2];
        end
      end
    end
  end

  AST_SDA_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (sclQ[1] && $past(sclQ[1]) && !startDet && !stopDet) |-> $stable(sdaLow)); // R10
  AST_BUSY_NACKS_ADDRESS: assert property (@(posedge clk) disable iff (!rstN)
    (ackStart && state == ST_DEV && busy) |=> !sdaLow); // R6
endmodule

// File: rtl/pagedEepromI2c.sv
module pagedEepromI2c
  import eePkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int OFS_W        = 4,
  parameter int DATA_W       = 8,
  parameter int WRITE_CYCLES = 1300000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaPullLow,
  input  logic [1:0] devSel,
  input  logic       wpN
);
  eeStrobe_t         strb;
  logic [DATA_W-1:0] rxByte, rdByte;
  logic              busy;

  eeCtrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .devSel(devSel),
    .busy(busy), .rdByte(rdByte), .strb(strb), .rxByte(rxByte), .sdaLow(sdaPullLow)
  );

  eeDatapath #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .DATA_W(DATA_W),
               .WRITE_CYCLES(WRITE_CYCLES)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .dataIn(rxByte), .wpN(wpN),
    .rdByte(rdByte), .busy(busy)
  );
endmodule

// File: tb/pagedEepromI2c_tb_top.sv
module pagedEepromI2c_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 5;    // clocks per quarter of a bus bit
  localparam int WCYC       = 300;
  localparam logic [7:0] DEVW = 8'hA4;  // prefix 10100, devSel 10, write
  localparam logic [7:0] DEVR = 8'hA5;
  // Vector: {start address, byte count, data base}
  localparam logic [23:0] VEC [4] = '{
    {8'h00, 8'd1,  8'h11},
    {8'h1F, 8'd2,  8'hA0},
    {8'h25, 8'd20, 8'h40},
    {8'hF8, 8'd4,  8'hC3}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1, wpN = 1'b1;
  logic [1:0] devSel = 2'b10;
  logic sdaPullLow;
  logic sdaBus;
  int checkCnt = 0, failCnt = 0, sdaViol = 0;
  bit done = 1'b0;
  logic [7:0] model [256];
  logic [7:0] ptrExp;
  logic [7:0] rdBuf [32];
  logic prevScl = 1'b1, prevDrv = 1'b0;

  assign sdaBus = sdaM & ~sdaPullLow;
  always #(CLK_PERIOD/2) clk = ~clk;

  pagedEepromI2c #(.WRITE_CYCLES(WCYC)) dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .sdaPullLow(sdaPullLow), .devSel(devSel), .wpN(wpN)
  );

  // R10 monitor: drive must not move while SCL stays high
  always @(negedge clk) begin
    if (rstN && sclM && prevScl && (sdaPullLow != prevDrv)) sdaViol++;
    prevScl <= sclM;
    prevDrv <= sdaPullLow;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic i2cStart();
    sdaM = 1'b1; tick(Q); sclM = 1'b1; tick(Q); sdaM = 1'b0; tick(Q); sclM = 1'b0; tick(Q);
  endtask

  task automatic i2cStop();
    sdaM = 1'b0; tick(Q); sclM = 1'b1; tick(Q); sdaM = 1'b1; tick(Q);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; tick(Q); sclM = 1'b1; tick(2*Q); sclM = 1'b0; tick(Q);
  endtask

  task automatic recvBit(output logic b);
    sdaM = 1'b1; tick(Q); sclM = 1'b1; tick(Q); b = sdaBus; tick(Q); sclM = 1'b0; tick(Q);
  endtask

  task automatic sendByte(input logic [7:0] d, output logic ack);
    logic nb;
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    recvBit(nb);
    ack = !nb;
  endtask

  task automatic recvByte(input logic giveAck, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) recvBit(d[i]);
    sendBit(!giveAck);
  endtask

  function automatic logic [7:0] pat(input logic [7:0] base, input int i);
    return base + 8'(i * 7);
  endfunction

  task automatic pageWrite(input logic [7:0] addr, input int n, input logic [7:0] base);
    logic ack;
    i2cStart();
    sendByte(DEVW, ack);
    sendByte(addr, ack);
    for (int i = 0; i < n; i++) begin
      sendByte(pat(base, i), ack);
      if (wpN) model[{addr[7:4], addr[3:0] + 4'(i)}] = pat(base, i);
    end
    i2cStop();
    ptrExp = {addr[7:4], addr[3:0] + 4'(n)};
  endtask

  task automatic randomRead(input logic [7:0] addr, input int n);
    logic ack;
    i2cStart();
    sendByte(DEVW, ack);
    sendByte(addr, ack);
    i2cStart();
    sendByte(DEVR, ack);
    for (int i = 0; i < n; i++) recvByte(i != n - 1, rdBuf[i]);
    i2cStop();
    ptrExp = addr + 8'(n);
  endtask

  task automatic currentRead(input int n);
    logic ack;
    i2cStart();
    sendByte(DEVR, ack);
    for (int i = 0; i < n; i++) recvByte(i != n - 1, rdBuf[i]);
    i2cStop();
    ptrExp = ptrExp + 8'(n);
  endtask

  task automatic pollReady(output int tries);
    logic ack;
    tries = 0;
    do begin
      tries++;
      i2cStart();
      sendByte(DEVW, ack);
      i2cStop();
    end while (!ack && tries < 40);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", checkCnt, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] d;
    int tries;
    for (int i = 0; i < 256; i++) model[i] = 8'hFF;
    ptrExp = 8'h00;
    tick(5);
    rstN = 1'b1;
    tick(5);

    // R1: released bus and erased contents after reset
    check(sdaPullLow == 1'b0, "R1 sda released", sdaPullLow, 0);
    currentRead(2);
    check(rdBuf[0] == 8'hFF, "R1 byte0 erased", rdBuf[0], 8'hFF);
    check(rdBuf[1] == 8'hFF, "R1 byte1 erased / R7 current read", rdBuf[1], 8'hFF);

    // R2: address decode
    devSel = 2'b01;
    i2cStart(); sendByte(DEVW, ack); i2cStop();
    check(!ack, "R2 foreign address nacked", ack, 0);
    devSel = 2'b10;
    i2cStart(); sendByte(8'hA0, ack); i2cStop();
    check(!ack, "R2 wrong select bits nacked", ack, 0);
    i2cStart(); sendByte(DEVW, ack); i2cStop();
    check(ack, "R2 own address acked", ack, 1);

    // Vector walk: page writes, polling, counter position, page readback
    foreach (VEC[v]) begin
      pageWrite(VEC[v][23:16], int'(VEC[v][15:8]), VEC[v][7:0]);
      pollReady(tries);
      check(tries > 1, "R6 first poll nacked", tries, 2);
      check(tries < 40, "R6 ack after cycle", tries, 2);
      d = model[ptrExp];
      currentRead(1);
      check(rdBuf[0] == d, "R4 counter after page write", rdBuf[0], d);
      randomRead({VEC[v][23:20], 4'h0}, 16);
      for (int i = 0; i < 16; i++)
        check(rdBuf[i] == model[{VEC[v][23:20], 4'(i)}], "R4 R5 page contents",
              rdBuf[i], model[{VEC[v][23:20], 4'(i)}]);
    end

    // R6: poll immediately after a stop, then again after a long wait
    pageWrite(8'h70, 1, 8'h3C);
    i2cStart(); sendByte(DEVW, ack); i2cStop();
    check(!ack, "R6 busy nacks address", ack, 0);
    tick(WCYC + 20);
    i2cStart(); sendByte(DEVW, ack); i2cStop();
    check(ack, "R6 ready after cycle", ack, 1);

    // R3: read wraps from 255 to 0, R7 current read follows
    randomRead(8'hFE, 4);
    check(rdBuf[0] == model[8'hFE], "R3 read FE", rdBuf[0], model[8'hFE]);
    check(rdBuf[1] == model[8'hFF], "R3 read FF", rdBuf[1], model[8'hFF]);
    check(rdBuf[2] == model[8'h00], "R3 wrap to 00", rdBuf[2], model[8'h00]);
    check(rdBuf[3] == model[8'h01], "R3 read 01", rdBuf[3], model[8'h01]);
    currentRead(1);
    check(rdBuf[0] == model[8'h02], "R7 current read resumes", rdBuf[0], model[8'h02]);

    // R8: write protect
    wpN = 1'b0;
    pageWrite(8'h50, 3, 8'h99);
    pollReady(tries);
    check(tries == 1, "R8 no write cycle when protected", tries, 1);
    randomRead(8'h50, 3);
    for (int i = 0; i < 3; i++)
      check(rdBuf[i] == 8'hFF, "R8 array unchanged", rdBuf[i], 8'hFF);
    wpN = 1'b1;

    // R9: data followed by repeated start is dropped
    i2cStart();
    sendByte(DEVW, ack);
    sendByte(8'h60, ack);
    sendByte(8'h5A, ack);
    i2cStart();
    sendByte(DEVR, ack);
    check(ack, "R9 no write cycle after repeated start", ack, 1);
    recvByte(1'b0, d);
    i2cStop();
    check(d == model[8'h61], "R9 R7 counter advanced in page", d, model[8'h61]);
    randomRead(8'h60, 1);
    check(rdBuf[0] == 8'hFF, "R9 discarded data not stored", rdBuf[0], 8'hFF);

    check(sdaViol == 0, "R10 sda steady while scl high", sdaViol, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule